// File: doc/BRIEF.md
# Atomic Swap Memory Controller

This block sits in front of a word-addressed storage array and serves several requesters. Each requester has its own request port with a valid/ready handshake. All requesters share one response port. The block handles four commands: plain read, plain write, and two atomic read-modify-write commands. Test-and-set returns the old word and leaves the value 1 behind. Exchange returns the old word and stores the data supplied with the request.

The storage is modelled as a pipeline with a fixed latency. The controller accepts at most one request per cycle, so responses leave in the order requests were accepted. Each response carries the requester index and the tag from the request, so the requester can match split responses to its own requests.

An atomic command reads when it is accepted and writes back only at the end of the pipeline. Between those two points a small lock table holds the command's address. Any later request to that address stalls at its port until the write-back completes. Requests to other addresses continue to flow. An atomic request also stalls when every lock entry is occupied.

Top module: `atomic_swap_ctrl`

## Requirements
- R1: While reset is held and after it is released, no request is accepted unless its valid is high, rsp_valid stays low until a response is due, and every storage word reads as zero.
- R2: A read (op code 2'b00) accepted at clock edge t returns the word stored at that address, presented with rsp_valid high in the cycle that follows edge t+MEM_LAT-1.
- R3: A write (op code 2'b01) stores its data so that any request accepted later sees it. Its response arrives with the same timing as a read, and its data field is zero.
- R4: A test-and-set (op code 2'b10) returns the word previously stored at the address and leaves the value 1 stored there.
- R5: An exchange (op code 2'b11) returns the word previously stored at the address and stores the request's data in its place.
- R6: Once an atomic command is accepted at edge t, no request to the same address is accepted at edges t+1 through t+MEM_LAT. The stalled request keeps its valid high, gets no ready, and when accepted later sees the value written back.
- R7: A request to an address that no atomic command holds is not delayed by an atomic command that is still in flight.
- R8: At most NUM_LOCKS atomic commands are in flight at once. A further atomic request stalls until a lock entry frees, which happens at the write-back edge of the oldest command.
- R9: Each response carries on rsp_id the index of the requester that issued it and on rsp_tag the tag sent with the request.
- R10: At most one request is accepted per cycle, and ready is never given to a port whose valid is low. Among the ports that are not stalled, the lowest index wins, so a stalled port does not hold back the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Request valid, one bit per requester |
| req_ready | output | NUM_REQ | Request accepted this cycle, one bit per requester |
| req_op | input | 2*NUM_REQ | Command code per requester |
| req_addr | input | ADDR_W*NUM_REQ | Word address per requester |
| req_wdata | input | DATA_W*NUM_REQ | Write or exchange data per requester |
| req_tag | input | TAG_W*NUM_REQ | Request tag per requester |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | ID_W | Index of the requester owning the response |
| rsp_tag | output | TAG_W | Tag echoed from the request |
| rsp_data | output | DATA_W | Old word for reads and atomics, zero for writes |

## Verification
The bench runs single commands of each kind on fresh and on already written words. These runs separate the two atomic commands from each other and from plain reads through the value left behind. Two requesters then aim at the same address, one cycle apart, with an atomic command first. This pattern tells a controller that stalls the second request apart from one that lets it read stale data, and the acceptance cycle is measured. The same timing is then used on different addresses, where any stall would be a fault. A burst of five atomic commands on distinct addresses exposes the lock-table limit, and two requests raised in the same cycle show the port priority.

// File: rtl/atomic_swap_pkg.sv
package atomic_swap_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_TAS   = 2'b10,
      OP_XCHG  = 2'b11
   } swap_op_e;

   // Upper code bit marks a read-modify-write command
   function automatic logic op_is_atomic(input swap_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/swap_lock_table.sv
module swap_lock_table #(
   parameter int NUM_REQ   = 2,
   parameter int ADDR_W    = 4,
   parameter int NUM_LOCKS = 4,
   parameter int LK_W      = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REQ*ADDR_W-1:0] probe_addr,
   output logic [NUM_REQ-1:0]        probe_hit,
   output logic                      full,
   output logic [LK_W-1:0]           free_idx,
   input  logic                      set_en,
   input  logic [ADDR_W-1:0]         set_addr,
   input  logic                      clr_en,
   input  logic [LK_W-1:0]           clr_idx
);

   logic [NUM_LOCKS-1:0] lk_vld;
   logic [ADDR_W-1:0]    lk_addr [NUM_LOCKS];

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_probe
      logic [NUM_LOCKS-1:0] match;
      always_comb begin
         for (int j = 0; j < NUM_LOCKS; j++) begin
            match[j] = lk_vld[j] && (lk_addr[j] == probe_addr[g*ADDR_W +: ADDR_W]);
         end
      end
      assign probe_hit[g] = |match;
   end

   always_comb begin
      free_idx = '0;
      for (int j = NUM_LOCKS - 1; j >= 0; j--) begin
         if (!lk_vld[j]) free_idx = LK_W'(j);
      end
   end

   assign full = &lk_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_vld <= '0;
         for (int j = 0; j < NUM_LOCKS; j++) lk_addr[j] <= '0;
      end else begin
         if (clr_en) lk_vld[clr_idx] <= 1'b0;
         if (set_en) begin
            lk_vld[free_idx]  <= 1'b1;
            lk_addr[free_idx] <= set_addr;
         end
      end
   end

endmodule

// File: rtl/swap_arbiter.sv
module swap_arbiter #(
   parameter int NUM_REQ = 2,
   parameter int ID_W    = 1
) (
   input  logic [NUM_REQ-1:0] elig,
   output logic [NUM_REQ-1:0] grant,
   output logic [ID_W-1:0]    grant_id,
   output logic               grant_any
);

   always_comb begin
      grant    = '0;
      grant_id = '0;
      for (int i = NUM_REQ - 1; i >= 0; i--) begin
         if (elig[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            grant_id = ID_W'(i);
         end
      end
   end

   assign grant_any = |elig;

endmodule

// File: rtl/swap_mem_pipe.sv
module swap_mem_pipe
   import atomic_swap_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int TAG_W   = 4,
   parameter int ID_W    = 1,
   parameter int LK_W    = 2,
   parameter int MEM_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_en,
   input  swap_op_e          iss_op,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic [DATA_W-1:0] iss_wdata,
   input  logic [ID_W-1:0]   iss_id,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic [LK_W-1:0]   iss_lock,
   output logic              rsp_valid,
   output logic [ID_W-1:0]   rsp_id,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data,
   output logic              wb_en,
   output logic [LK_W-1:0]   wb_lock
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int LAST  = MEM_LAT - 1;

   logic [DATA_W-1:0] mem     [DEPTH];
   logic              st_vld  [MEM_LAT];
   swap_op_e          st_op   [MEM_LAT];
   logic [ADDR_W-1:0] st_addr [MEM_LAT];
   logic [DATA_W-1:0] st_new  [MEM_LAT];
   logic [DATA_W-1:0] st_old  [MEM_LAT];
   logic [ID_W-1:0]   st_id   [MEM_LAT];
   logic [TAG_W-1:0]  st_tag  [MEM_LAT];
   logic [LK_W-1:0]   st_lock [MEM_LAT];

   logic [DATA_W-1:0] iss_new;

   assign iss_new = (iss_op == OP_TAS) ? DATA_W'(1) : iss_wdata;
   assign wb_en   = st_vld[LAST] && op_is_atomic(st_op[LAST]);
   assign wb_lock = st_lock[LAST];

   // Storage with two write ports: plain writes at issue, atomic write-back at the end
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      end else begin
         if (iss_en && iss_op == OP_WRITE) mem[iss_addr] <= iss_wdata;
         if (wb_en) mem[st_addr[LAST]] <= st_new[LAST];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_vld[0] <= 1'b0;
      else        st_vld[0] <= iss_en;
   end

   always_ff @(posedge clk) begin
      st_op[0]   <= iss_op;
      st_addr[0] <= iss_addr;
      st_new[0]  <= iss_new;
      st_old[0]  <= mem[iss_addr];
      st_id[0]   <= iss_id;
      st_tag[0]  <= iss_tag;
      st_lock[0] <= iss_lock;
   end

   if (MEM_LAT > 1) begin : g_shift
      for (genvar k = 1; k < MEM_LAT; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) st_vld[k] <= 1'b0;
            else        st_vld[k] <= st_vld[k-1];
         end
         always_ff @(posedge clk) begin
            st_op[k]   <= st_op[k-1];
            st_addr[k] <= st_addr[k-1];
            st_new[k]  <= st_new[k-1];
            st_old[k]  <= st_old[k-1];
            st_id[k]   <= st_id[k-1];
            st_tag[k]  <= st_tag[k-1];
            st_lock[k] <= st_lock[k-1];
         end
      end
   end

   assign rsp_valid = st_vld[LAST];
   assign rsp_id    = st_id[LAST];
   assign rsp_tag   = st_tag[LAST];
   assign rsp_data  = (st_op[LAST] == OP_WRITE) ? '0 : st_old[LAST];

endmodule

// File: rtl/atomic_swap_ctrl.sv
module atomic_swap_ctrl
   import atomic_swap_pkg::*;
#(
   parameter int NUM_REQ   = 2,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 4,
   parameter int MEM_LAT   = 3,
   parameter int NUM_LOCKS = 4,
   localparam int ID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
   localparam int LK_W     = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REQ-1:0]        req_valid,
   output logic [NUM_REQ-1:0]        req_ready,
   input  logic [NUM_REQ*2-1:0]      req_op,
   input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
   input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
   input  logic [NUM_REQ*TAG_W-1:0]  req_tag,
   output logic                      rsp_valid,
   output logic [ID_W-1:0]           rsp_id,
   output logic [TAG_W-1:0]          rsp_tag,
   output logic [DATA_W-1:0]         rsp_data
);

   if (MEM_LAT < 1) begin : g_bad_lat
      $error("MEM_LAT must be at least 1");
   end
   if (NUM_LOCKS < 1) begin : g_bad_locks
      $error("NUM_LOCKS must be at least 1");
   end
   if (NUM_REQ < 1) begin : g_bad_req
      $error("NUM_REQ must be at least 1");
   end

   logic [NUM_REQ-1:0] lk_hit;
   logic [NUM_REQ-1:0] elig;
   logic               lk_full;
   logic [LK_W-1:0]    lk_free;
   logic [ID_W-1:0]    gnt_id;
   logic               gnt_any;
   logic               wb_en;
   logic [LK_W-1:0]    wb_lock;
   swap_op_e           sel_op;
   logic [ADDR_W-1:0]  sel_addr;
   logic [DATA_W-1:0]  sel_wdata;
   logic [TAG_W-1:0]   sel_tag;

   // A port is eligible unless its address is locked, or it is atomic and no entry is free
   for (genvar g = 0; g < NUM_REQ; g++) begin : g_elig
      assign elig[g] = req_valid[g] && !lk_hit[g] && !(req_op[g*2+1] && lk_full);
   end

   swap_lock_table #(
      .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .LK_W(LK_W)
   ) u_locks (
      .clk       (clk),
      .rst_n     (rst_n),
      .probe_addr(req_addr),
      .probe_hit (lk_hit),
      .full      (lk_full),
      .free_idx  (lk_free),
      .set_en    (gnt_any && op_is_atomic(sel_op)),
      .set_addr  (sel_addr),
      .clr_en    (wb_en),
      .clr_idx   (wb_lock)
   );

   swap_arbiter #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_arb (
      .elig     (elig),
      .grant    (req_ready),
      .grant_id (gnt_id),
      .grant_any(gnt_any)
   );

   assign sel_op    = swap_op_e'(req_op[int'(gnt_id)*2 +: 2]);
   assign sel_addr  = req_addr[int'(gnt_id)*ADDR_W +: ADDR_W];
   assign sel_wdata = req_wdata[int'(gnt_id)*DATA_W +: DATA_W];
   assign sel_tag   = req_tag[int'(gnt_id)*TAG_W +: TAG_W];

   swap_mem_pipe #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
      .ID_W(ID_W), .LK_W(LK_W), .MEM_LAT(MEM_LAT)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_en   (gnt_any),
      .iss_op   (sel_op),
      .iss_addr (sel_addr),
      .iss_wdata(sel_wdata),
      .iss_id   (gnt_id),
      .iss_tag  (sel_tag),
      .iss_lock (lk_free),
      .rsp_valid(rsp_valid),
      .rsp_id   (rsp_id),
      .rsp_tag  (rsp_tag),
      .rsp_data (rsp_data),
      .wb_en    (wb_en),
      .wb_lock  (wb_lock)
   );

endmodule

// File: rtl/atomic_swap_chk.sv
module atomic_swap_chk #(
   parameter int NUM_REQ   = 2,
   parameter int ADDR_W    = 4,
   parameter int TAG_W     = 4,
   parameter int MEM_LAT   = 3,
   parameter int NUM_LOCKS = 4,
   parameter int ID_W      = 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_REQ-1:0]        req_valid,
   input logic [NUM_REQ-1:0]        req_ready,
   input logic [NUM_REQ*2-1:0]      req_op,
   input logic [NUM_REQ*ADDR_W-1:0] req_addr,
   input logic [NUM_REQ*TAG_W-1:0]  req_tag,
   input logic                      rsp_valid,
   input logic [ID_W-1:0]           rsp_id,
   input logic [TAG_W-1:0]          rsp_tag
);

   localparam int LAST = MEM_LAT - 1;

   logic              acc;
   logic              acc_atom;
   logic [ADDR_W-1:0] acc_addr;
   logic [TAG_W-1:0]  acc_tag;
   logic [ID_W-1:0]   acc_id;
   logic              conflict;
   logic [MEM_LAT-1:0] sh_vld;
   logic [MEM_LAT-1:0] sh_atom;
   logic [ADDR_W-1:0]  sh_addr [MEM_LAT];
   logic [ID_W-1:0]    sh_id   [MEM_LAT];
   logic [TAG_W-1:0]   sh_tag  [MEM_LAT];

   always_comb begin
      acc      = 1'b0;
      acc_atom = 1'b0;
      acc_addr = '0;
      acc_tag  = '0;
      acc_id   = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (req_ready[i]) begin
            acc      = 1'b1;
            acc_atom = req_op[i*2+1];
            acc_addr = req_addr[i*ADDR_W +: ADDR_W];
            acc_tag  = req_tag[i*TAG_W +: TAG_W];
            acc_id   = ID_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_vld  <= '0;
         sh_atom <= '0;
      end else begin
         sh_vld  <= {sh_vld[MEM_LAT-2:0], acc};
         sh_atom <= {sh_atom[MEM_LAT-2:0], acc && acc_atom};
      end
   end

   always_ff @(posedge clk) begin
      sh_addr[0] <= acc_addr;
      sh_id[0]   <= acc_id;
      sh_tag[0]  <= acc_tag;
      for (int k = 1; k < MEM_LAT; k++) begin
         sh_addr[k] <= sh_addr[k-1];
         sh_id[k]   <= sh_id[k-1];
         sh_tag[k]  <= sh_tag[k-1];
      end
   end

   always_comb begin
      conflict = 1'b0;
      for (int k = 0; k < MEM_LAT; k++) begin
         if (acc && sh_atom[k] && sh_addr[k] == acc_addr) conflict = 1'b1;
      end
   end

   AST_READY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready)); // R10
   AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0); // R10
   AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == sh_vld[LAST]); // R2
   AST_RSP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_id == sh_id[LAST] && rsp_tag == sh_tag[LAST])); // R9
   AST_NO_LOCKED_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !conflict); // R6
   AST_LOCK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sh_atom) <= NUM_LOCKS); // R8

endmodule

bind atomic_swap_ctrl atomic_swap_chk #(
   .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
   .MEM_LAT(MEM_LAT), .NUM_LOCKS(NUM_LOCKS), .ID_W(ID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_op(req_op), .req_addr(req_addr), .req_tag(req_tag),
   .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_tag(rsp_tag)
);

// File: tb/atomic_swap_ctrl_tb.sv
module atomic_swap_ctrl_tb;

   localparam int LAT = 6;
   localparam int NR  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tb_vld  [NR];
   logic [1:0]  tb_op   [NR];
   logic [3:0]  tb_addr [NR];
   logic [31:0] tb_wd   [NR];
   logic [3:0]  tb_tag  [NR];
   logic [NR-1:0]    req_valid, req_ready;
   logic [NR*2-1:0]  req_op;
   logic [NR*4-1:0]  req_addr, req_tag;
   logic [NR*32-1:0] req_wdata;
   logic        rsp_valid;
   logic        rsp_id;
   logic [3:0]  rsp_tag;
   logic [31:0] rsp_data;

   assign req_valid = {tb_vld[1], tb_vld[0]};
   assign req_op    = {tb_op[1], tb_op[0]};
   assign req_addr  = {tb_addr[1], tb_addr[0]};
   assign req_wdata = {tb_wd[1], tb_wd[0]};
   assign req_tag   = {tb_tag[1], tb_tag[0]};

   atomic_swap_ctrl #(.NUM_REQ(NR), .ADDR_W(4), .DATA_W(32), .TAG_W(4),
                      .MEM_LAT(LAT), .NUM_LOCKS(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
      .rsp_tag(rsp_tag), .rsp_data(rsp_data)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          id;
      logic [3:0]  tag;
      logic [31:0] data;
      int          due;
      string       req;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] model [16];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Driver: present a request, wait for ready, push the expected response
   task automatic drive(input int r, input logic [1:0] op, input logic [3:0] addr,
                        input logic [31:0] wd, input logic [3:0] tag,
                        input string req, output int acc);
      exp_t e;
      tb_vld[r] = 1'b1; tb_op[r] = op; tb_addr[r] = addr;
      tb_wd[r] = wd; tb_tag[r] = tag;
      #1;
      while (!req_ready[r]) begin
         @(negedge clk);
         #1;
      end
      acc    = cyc;
      e.id   = r;
      e.tag  = tag;
      e.due  = cyc + LAT;
      e.req  = req;
      e.data = (op == 2'b01) ? 32'h0 : model[addr];
      case (op)
         2'b01:   model[addr] = wd;
         2'b10:   model[addr] = 32'h1;
         2'b11:   model[addr] = wd;
         default: ;
      endcase
      sb.push_back(e);
      @(negedge clk);
      tb_vld[r] = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pop and compare every response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2", "unexpected response", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_data == e.data, e.req, "data", rsp_data, e.data);
            check(int'(rsp_id) == e.id && rsp_tag == e.tag, "R9", "id/tag",
                  {rsp_id, rsp_tag}, {e.id[0], e.tag});
            check(cyc == e.due, "R2", "response cycle", cyc, e.due);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int a0, a1, a2, a3, a4, t;
      for (int i = 0; i < NR; i++) begin
         tb_vld[i] = 0; tb_op[i] = 0; tb_addr[i] = 0; tb_wd[i] = 0; tb_tag[i] = 0;
      end
      for (int i = 0; i < 16; i++) model[i] = 32'h0;
      repeat (3) @(negedge clk);
      check(req_ready == '0 && rsp_valid == 1'b0, "R1", "idle in reset",
            {req_ready, rsp_valid}, 0);
      rst_n = 1'b1;
      idle(2);
      check(req_ready == '0 && rsp_valid == 1'b0, "R1", "idle after reset",
            {req_ready, rsp_valid}, 0);

      // R1/R2: fresh read returns zero
      drive(0, 2'b00, 4'd3, 0, 4'h1, "R1", t);
      // R3 then R2: write, then read back
      drive(1, 2'b01, 4'd2, 32'hCAFE_0123, 4'h2, "R3", t);
      drive(0, 2'b00, 4'd2, 0, 4'h3, "R2", t);
      // R4: test-and-set twice on the same word, then read
      idle(LAT + 2);
      drive(0, 2'b10, 4'd4, 32'hFFFF, 4'h4, "R4", t);
      idle(LAT + 2);
      drive(1, 2'b10, 4'd4, 0, 4'h5, "R4", t);
      idle(LAT + 2);
      drive(0, 2'b00, 4'd4, 0, 4'h6, "R4", t);
      // R5: exchange on a written word, then read
      drive(1, 2'b11, 4'd2, 32'h5555_AAAA, 4'h7, "R5", t);
      idle(LAT + 2);
      drive(0, 2'b00, 4'd2, 0, 4'h8, "R5", t);
      idle(LAT + 2);

      // R6: same address one cycle later from the other port is held off
      fork
         drive(0, 2'b10, 4'd8, 0, 4'h9, "R4", a0);
         begin @(negedge clk); drive(1, 2'b00, 4'd8, 0, 4'hA, "R6", a1); end
      join
      check(a1 - a0 == LAT + 1, "R6", "stall length", a1 - a0, LAT + 1);
      idle(LAT + 2);
      // R6: a write held off behind an exchange lands afterwards
      fork
         drive(1, 2'b11, 4'd7, 32'h0000_0077, 4'hB, "R5", a0);
         begin @(negedge clk); drive(0, 2'b01, 4'd7, 32'h0000_0099, 4'hC, "R6", a1); end
      join
      check(a1 - a0 == LAT + 1, "R6", "write stall", a1 - a0, LAT + 1);
      drive(1, 2'b00, 4'd7, 0, 4'hD, "R6", t);
      idle(LAT + 2);

      // R7: other address proceeds while a lock is held
      fork
         drive(0, 2'b11, 4'd9, 32'h1234, 4'hE, "R5", a0);
         begin @(negedge clk); drive(1, 2'b00, 4'd2, 0, 4'hF, "R7", a1); end
      join
      check(a1 - a0 == 1, "R7", "no stall", a1 - a0, 1);
      idle(LAT + 2);

      // R8: fifth atomic waits for the oldest lock to free
      drive(0, 2'b10, 4'd11, 0, 4'h1, "R8", a0);
      drive(0, 2'b11, 4'd12, 32'h12, 4'h2, "R8", a1);
      drive(0, 2'b10, 4'd13, 0, 4'h3, "R8", a2);
      drive(0, 2'b11, 4'd14, 32'h14, 4'h4, "R8", a3);
      drive(0, 2'b10, 4'd15, 0, 4'h5, "R8", a4);
      check(a3 - a0 == 3, "R8", "four locks back to back", a3 - a0, 3);
      check(a4 - a0 == LAT + 1, "R8", "fifth atomic stall", a4 - a0, LAT + 1);
      idle(LAT + 2);

      // R10: simultaneous requests, lowest index first
      fork
         drive(0, 2'b00, 4'd12, 0, 4'h6, "R10", a0);
         drive(1, 2'b00, 4'd14, 0, 4'h7, "R10", a1);
      join
      check(a1 - a0 == 1, "R10", "port 0 first", a1 - a0, 1);
      idle(LAT + 3);
      check(sb.size() == 0, "R2", "responses drained", sb.size(), 0);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule